// File: doc/BRIEF.md
# Aliased register-write dispatcher

This block applies a stream of register writes to a set of internal registers. A command header gives a base register ID, the number of 32-bit parameters that follow, and a flag that selects whether the ID steps up by one for each parameter. Each parameter is then routed by the register ID it resolves to. The destination is one of four kinds. A configuration ID stores the value in a small register file, which downstream logic reads through a combinational port. A data ID pushes the value into an external FIFO through a valid/ready handshake. An action ID raises a one-cycle pulse that carries the value. A terminate ID ends the current buffer.

The data ID range 0x2C1..0x2C8 all aliases one FIFO. The ID just below it, 0x2C0, is a configuration register. A single stepping burst based at 0x2C0 therefore loads that configuration register and then streams every later word into the FIFO. After a terminate write, `done_o` rises. All further parameters are consumed and discarded until `buf_start_i` opens a new buffer. If no terminate write arrives, `done_o` stays low.

Top module: `reg_write_dispatch`

## Requirements
- R1: After reset, `done_o` is 0, `cmd_ready_o` is 1, `par_ready_o` is 0, `fifo_valid_o` is 0, `act_pulse_o` is 0 and every configuration slot reads 0.
- R2: A parameter whose ID is 0x040+k (k from 0 to 7) is stored in configuration slot k. The value is readable on `cfg_rd_data_o` from the cycle after the parameter is accepted.
- R3: With `cmd_consec_i`=1, parameter n of a command goes to base+n. With `cmd_consec_i`=0, every parameter goes to the base ID, so the last one wins.
- R4: ID 0x2C0 is configuration slot 8. IDs 0x2C1 through 0x2C8 each push onto the FIFO. A stepping burst of 10 words based at 0x2C0 stores word 0 in slot 8, pushes words 1 to 8 in order, and drops word 9 (ID 0x2C9, unmapped).
- R5: While a data parameter waits and `fifo_ready_i` is 0, `par_ready_o` is 0 and the current ID is held. The stream resumes with the same ID once the FIFO is ready.
- R6: A parameter to ID 0x020+k (k from 0 to 3) raises `act_pulse_o` bit k alone for exactly the one cycle after acceptance. In that cycle `act_data_o` equals the parameter.
- R7: A parameter to an unmapped ID is accepted and changes no configuration slot, no FIFO push, no pulse and not `done_o`.
- R8: A parameter to ID 0x010 sets `done_o` from the cycle after acceptance, whatever its value.
- R9: While `done_o` is 1 (and `buf_start_i` is 0), parameters are accepted, even to a full FIFO, and discarded with no effect at any output or slot.
- R10: `buf_start_i` clears `done_o` in the next cycle. A parameter accepted in that same cycle belongs to the new buffer and takes effect. If it is a terminate write, `done_o` remains 1.
- R11: A header with a count of 0 consumes no parameter. The dispatcher stays ready for a new header, with `par_ready_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_start_i | input | 1 | Opens a new buffer, clears the terminated state |
| cmd_valid_i | input | 1 | Header valid |
| cmd_ready_o | output | 1 | Header accepted (dispatcher idle) |
| cmd_base_i | input | 10 | Base register ID |
| cmd_count_i | input | CNT_W | Number of parameters |
| cmd_consec_i | input | 1 | 1: ID steps per parameter, 0: fixed ID |
| par_valid_i | input | 1 | Parameter valid |
| par_ready_o | output | 1 | Parameter accepted |
| par_data_i | input | DATA_W | Parameter value |
| cfg_rd_addr_i | input | clog2(CFG_NUM+1) | Configuration slot to read |
| cfg_rd_data_o | output | DATA_W | Configuration slot contents |
| fifo_valid_o | output | 1 | FIFO push request |
| fifo_ready_i | input | 1 | FIFO has space |
| fifo_data_o | output | DATA_W | FIFO push data |
| act_pulse_o | output | ACT_NUM | One-hot action strobe |
| act_data_o | output | DATA_W | Value carried with the strobe |
| done_o | output | 1 | Buffer terminated |

## Verification
Buffer start and a write acceptance can fall in the same cycle. That collision decides whether the word is discarded as part of the old buffer or applied as part of the new one. The bench provokes it by raising `buf_start_i` together with the first parameter of a command while `done_o` is 1. It does this once with a configuration write, which must land in its slot while `done_o` falls, and once with a terminate write, after which `done_o` must stay high and a following write must be dropped. A FIFO stall that coincides with a stepping ID is also forced, and the number of words pushed shows whether the ID advanced during the stall.

// File: rtl/reg_dispatch_pkg.sv
package reg_dispatch_pkg;
  localparam int unsigned REG_ID_W = 10;

  typedef enum logic [2:0] {
    K_NONE,
    K_CFG,
    K_FIFO,
    K_ACT,
    K_FIN
  } dst_kind_e;

  typedef enum logic {
    S_IDLE,
    S_STREAM
  } seq_state_e;
endpackage

// File: rtl/reg_id_decode.sv
module reg_id_decode
  import reg_dispatch_pkg::*;
#(
  parameter int unsigned CFG_BASE    = 'h040,
  parameter int unsigned CFG_NUM     = 8,
  parameter int unsigned ACT_BASE    = 'h020,
  parameter int unsigned ACT_NUM     = 4,
  parameter int unsigned FIN_ID      = 'h010,
  parameter int unsigned UNI_CFG_ID  = 'h2C0,
  parameter int unsigned UNI_DATA_LO = 'h2C1,
  parameter int unsigned UNI_DATA_HI = 'h2C8,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [REG_ID_W-1:0] id_i,
  output dst_kind_e           kind_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [REG_ID_W-1:0] cfg_off, act_off;

  assign cfg_off = id_i - REG_ID_W'(CFG_BASE);
  assign act_off = id_i - REG_ID_W'(ACT_BASE);

  // terminate and alias window take priority over the plain ranges
  always_comb begin
    kind_o = K_NONE;
    idx_o  = '0;
    if (id_i == REG_ID_W'(FIN_ID)) begin
      kind_o = K_FIN;
    end else if (id_i == REG_ID_W'(UNI_CFG_ID)) begin
      kind_o = K_CFG;
      idx_o  = IDX_W'(CFG_NUM);
    end else if (id_i >= REG_ID_W'(UNI_DATA_LO) && id_i <= REG_ID_W'(UNI_DATA_HI)) begin
      kind_o = K_FIFO;
    end else if (id_i >= REG_ID_W'(CFG_BASE) && cfg_off < REG_ID_W'(CFG_NUM)) begin
      kind_o = K_CFG;
      idx_o  = cfg_off[IDX_W-1:0];
    end else if (id_i >= REG_ID_W'(ACT_BASE) && act_off < REG_ID_W'(ACT_NUM)) begin
      kind_o = K_ACT;
      idx_o  = act_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int unsigned SLOTS  = 9,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q[g] <= '0;
      else if (we_i && wa_i == AW'(g))      q[g] <= wd_i;
    end

    p_slot_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && wa_i == AW'(g) |=> q[g] == $past(wd_i));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < SLOTS; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = q[i];
  end
endmodule

// File: rtl/reg_write_dispatch.sv
module reg_write_dispatch
  import reg_dispatch_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned CFG_NUM     = 8,
  parameter int unsigned CFG_BASE    = 'h040,
  parameter int unsigned ACT_NUM     = 4,
  parameter int unsigned ACT_BASE    = 'h020,
  parameter int unsigned FIN_ID      = 'h010,
  parameter int unsigned UNI_CFG_ID  = 'h2C0,
  parameter int unsigned UNI_DATA_LO = 'h2C1,
  parameter int unsigned UNI_DATA_HI = 'h2C8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              buf_start_i,
  input  logic                              cmd_valid_i,
  output logic                              cmd_ready_o,
  input  logic [REG_ID_W-1:0]               cmd_base_i,
  input  logic [CNT_W-1:0]                  cmd_count_i,
  input  logic                              cmd_consec_i,
  input  logic                              par_valid_i,
  output logic                              par_ready_o,
  input  logic [DATA_W-1:0]                 par_data_i,
  input  logic [$clog2(CFG_NUM+1)-1:0]      cfg_rd_addr_i,
  output logic [DATA_W-1:0]                 cfg_rd_data_o,
  output logic                              fifo_valid_o,
  input  logic                              fifo_ready_i,
  output logic [DATA_W-1:0]                 fifo_data_o,
  output logic [ACT_NUM-1:0]                act_pulse_o,
  output logic [DATA_W-1:0]                 act_data_o,
  output logic                              done_o
);
  localparam int unsigned CFG_SLOTS = CFG_NUM + 1;
  localparam int unsigned CFG_AW    = $clog2(CFG_SLOTS);
  localparam int unsigned ACT_AW    = (ACT_NUM > 1) ? $clog2(ACT_NUM) : 1;
  localparam int unsigned IDX_W     = (CFG_AW > ACT_AW) ? CFG_AW : ACT_AW;

  seq_state_e          state_q;
  logic [REG_ID_W-1:0] cur_id_q;
  logic [CNT_W-1:0]    remain_q;
  logic                consec_q;
  logic                fin_q;
  logic [ACT_NUM-1:0]  act_pulse_q;
  logic [DATA_W-1:0]   act_data_q;

  dst_kind_e           kind;
  logic [IDX_W-1:0]    idx;
  logic                streaming, fin_eff, fifo_hit, fire, live;
  logic                cfg_we, fin_hit, act_hit;

  reg_id_decode #(
    .CFG_BASE   (CFG_BASE),
    .CFG_NUM    (CFG_NUM),
    .ACT_BASE   (ACT_BASE),
    .ACT_NUM    (ACT_NUM),
    .FIN_ID     (FIN_ID),
    .UNI_CFG_ID (UNI_CFG_ID),
    .UNI_DATA_LO(UNI_DATA_LO),
    .UNI_DATA_HI(UNI_DATA_HI),
    .IDX_W      (IDX_W)
  ) u_decode (
    .id_i  (cur_id_q),
    .kind_o(kind),
    .idx_o (idx)
  );

  // a buffer start in the same cycle makes the current word part of the new buffer
  assign streaming   = (state_q == S_STREAM);
  assign fin_eff     = fin_q & ~buf_start_i;
  assign fifo_hit    = streaming && kind == K_FIFO && !fin_eff;
  assign par_ready_o = streaming && (!fifo_hit || fifo_ready_i);
  assign cmd_ready_o = (state_q == S_IDLE);
  assign fire        = par_valid_i && par_ready_o;
  assign live        = fire && !fin_eff;
  assign cfg_we      = live && kind == K_CFG;
  assign fin_hit     = live && kind == K_FIN;
  assign act_hit     = live && kind == K_ACT;

  assign fifo_valid_o = fifo_hit && par_valid_i;
  assign fifo_data_o  = par_data_i;

  cfg_regfile #(
    .SLOTS (CFG_SLOTS),
    .DATA_W(DATA_W),
    .AW    (CFG_AW)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we),
    .wa_i     (idx[CFG_AW-1:0]),
    .wd_i     (par_data_i),
    .rd_addr_i(cfg_rd_addr_i),
    .rd_data_o(cfg_rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_id_q <= '0;
      remain_q <= '0;
      consec_q <= 1'b0;
    end else if (state_q == S_IDLE) begin
      if (cmd_valid_i) begin
        cur_id_q <= cmd_base_i;
        remain_q <= cmd_count_i;
        consec_q <= cmd_consec_i;
        state_q  <= (cmd_count_i != '0) ? S_STREAM : S_IDLE;
      end
    end else if (fire) begin
      if (consec_q) cur_id_q <= cur_id_q + 1'b1;
      remain_q <= remain_q - 1'b1;
      if (remain_q == CNT_W'(1)) state_q <= S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q       <= 1'b0;
      act_pulse_q <= '0;
      act_data_q  <= '0;
    end else begin
      fin_q       <= fin_hit | fin_eff;
      act_pulse_q <= act_hit ? (ACT_NUM'(1) << idx) : '0;
      if (act_hit) act_data_q <= par_data_i;
    end
  end

  assign act_pulse_o = act_pulse_q;
  assign act_data_o  = act_data_q;
  assign done_o      = fin_q;

  p_done_follows_fin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_hit |=> done_o);

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_start_i && !fin_hit |=> !done_o);

  p_no_act_after_fin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !buf_start_i |=> act_pulse_o == '0);

  p_act_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_pulse_o));

  p_stall_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o && !fifo_ready_i |-> !par_ready_o);

  p_id_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streaming && par_valid_i && !par_ready_o |=> $stable(cur_id_q));

  p_idle_no_par_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !fifo_valid_o);
endmodule

// File: tb/reg_write_dispatch_tb.sv
module reg_write_dispatch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_start = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [9:0]  cmd_base = '0;
  logic [7:0]  cmd_count = '0;
  logic        cmd_consec = 1'b0;
  logic        par_valid = 1'b0;
  logic        par_ready;
  logic [31:0] par_data = '0;
  logic [3:0]  cfg_rd_addr = '0;
  logic [31:0] cfg_rd_data;
  logic        fifo_valid;
  logic        fifo_ready = 1'b1;
  logic [31:0] fifo_data;
  logic [3:0]  act_pulse;
  logic [31:0] act_data;
  logic        done;

  int tests = 0;
  int fails = 0;
  int act_cnt = 0;
  logic [31:0] fq[$];
  logic [31:0] pdata [16];
  logic [31:0] cfg_m [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_write_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .buf_start_i(buf_start),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_base_i(cmd_base),
    .cmd_count_i(cmd_count), .cmd_consec_i(cmd_consec),
    .par_valid_i(par_valid), .par_ready_o(par_ready), .par_data_i(par_data),
    .cfg_rd_addr_i(cfg_rd_addr), .cfg_rd_data_o(cfg_rd_data),
    .fifo_valid_o(fifo_valid), .fifo_ready_i(fifo_ready), .fifo_data_o(fifo_data),
    .act_pulse_o(act_pulse), .act_data_o(act_data), .done_o(done)
  );

  always @(posedge clk) if (fifo_valid && fifo_ready) fq.push_back(fifo_data);
  always @(negedge clk) if (act_pulse != '0) act_cnt++;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    cfg_rd_addr = 4'(idx);
    #1;
    v = cfg_rd_data;
  endtask

  task automatic chk_slots(input string req);
    logic [31:0] v;
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      chk(req, $sformatf("slot %0d", i), v, cfg_m[i]);
    end
  endtask

  // ends 2 time units after the negedge that follows the last accepting edge
  task automatic send(input logic [9:0] base, input int cnt, input logic consec, input logic strt);
    logic taken;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_base = base; cmd_count = 8'(cnt); cmd_consec = consec;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      par_valid = 1'b1;
      par_data  = pdata[i];
      buf_start = strt && (i == 0);
      forever begin
        #1;
        taken = par_ready;
        @(posedge clk);
        @(negedge clk);
        if (taken) break;
      end
      buf_start = 1'b0;
    end
    par_valid = 1'b0;
    #2;
  endtask

  task automatic t_reset;
    chk("R1", "done_o", 32'(done), 0);
    chk("R1", "cmd_ready_o", 32'(cmd_ready), 1);
    chk("R1", "par_ready_o", 32'(par_ready), 0);
    chk("R1", "fifo_valid_o", 32'(fifo_valid), 0);
    chk("R1", "act_pulse_o", 32'(act_pulse), 0);
    chk_slots("R1");
  endtask

  task automatic t_cfg_consec;
    for (int i = 0; i < 3; i++) begin pdata[i] = 32'hA000_0000 + 32'(i); cfg_m[i] = pdata[i]; end
    send(10'h040, 3, 1'b1, 1'b0);
    chk_slots("R2 R3 consec");
  endtask

  task automatic t_nonconsec;
    for (int i = 0; i < 3; i++) pdata[i] = 32'hB000_0000 + 32'(i);
    cfg_m[1] = pdata[2];
    send(10'h041, 3, 1'b0, 1'b0);
    chk_slots("R3 fixed id");
  endtask

  task automatic t_alias;
    fq.delete();
    for (int i = 0; i < 10; i++) pdata[i] = 32'hC000_0000 + 32'(i);
    cfg_m[8] = pdata[0];
    send(10'h2C0, 10, 1'b1, 1'b0);
    chk_slots("R4 alias cfg");
    chk("R4", "fifo pushes", 32'(fq.size()), 8);
    for (int i = 0; i < 8 && i < fq.size(); i++)
      chk("R4", $sformatf("fifo word %0d", i), fq[i], pdata[i+1]);
  endtask

  task automatic t_stall;
    fq.delete();
    for (int i = 0; i < 3; i++) pdata[i] = 32'hD000_0000 + 32'(i);
    fifo_ready = 1'b0;
    fork
      send(10'h2C7, 3, 1'b1, 1'b0);
      begin
        repeat (5) @(negedge clk);
        #1;
        chk("R5", "par_ready_o during stall", 32'(par_ready), 0);
        chk("R5", "no push during stall", 32'(fq.size()), 0);
        @(negedge clk);
        fifo_ready = 1'b1;
      end
    join
    chk("R5", "pushes after stall", 32'(fq.size()), 2);
    if (fq.size() == 2) begin
      chk("R5", "word 0", fq[0], pdata[0]);
      chk("R5", "word 1", fq[1], pdata[1]);
    end
  endtask

  task automatic t_action;
    int c0;
    c0 = act_cnt;
    pdata[0] = 32'hE0E0_1234;
    send(10'h022, 1, 1'b0, 1'b0);
    chk("R6", "act_pulse_o", 32'(act_pulse), 32'b0100);
    chk("R6", "act_data_o", act_data, pdata[0]);
    @(negedge clk); #2;
    chk("R6", "pulse width", 32'(act_cnt - c0), 1);
    chk("R6", "pulse cleared", 32'(act_pulse), 0);
  endtask

  task automatic t_unmapped;
    int c0, f0;
    c0 = act_cnt; f0 = fq.size();
    pdata[0] = 32'h1111_2222; pdata[1] = 32'h3333_4444;
    send(10'h100, 2, 1'b1, 1'b0);
    @(negedge clk); #2;
    chk_slots("R7 unmapped");
    chk("R7", "no push", 32'(fq.size()), 32'(f0));
    chk("R7", "no pulse", 32'(act_cnt - c0), 0);
    chk("R7", "done_o", 32'(done), 0);
  endtask

  task automatic t_count0;
    send(10'h040, 0, 1'b1, 1'b0);
    chk("R11", "cmd_ready_o", 32'(cmd_ready), 1);
    par_valid = 1'b1; par_data = 32'hDEAD_0000;
    #1;
    chk("R11", "par_ready_o", 32'(par_ready), 0);
    par_valid = 1'b0;
    chk_slots("R11 slots");
  endtask

  task automatic t_finalize;
    pdata[0] = 32'h0000_0000;
    chk("R8", "done_o before", 32'(done), 0);
    send(10'h010, 1, 1'b0, 1'b0);
    chk("R8", "done_o after", 32'(done), 1);
  endtask

  task automatic t_drop;
    int c0, f0;
    c0 = act_cnt; f0 = fq.size();
    pdata[0] = 32'hF000_0004;
    send(10'h044, 1, 1'b0, 1'b0);
    fifo_ready = 1'b0;
    pdata[0] = 32'hF000_0010; pdata[1] = 32'hF000_0011;
    send(10'h2C1, 2, 1'b1, 1'b0);
    fifo_ready = 1'b1;
    pdata[0] = 32'hF000_0020;
    send(10'h020, 1, 1'b0, 1'b0);
    @(negedge clk); #2;
    chk_slots("R9 dropped cfg");
    chk("R9", "no push", 32'(fq.size()), 32'(f0));
    chk("R9", "no pulse", 32'(act_cnt - c0), 0);
    chk("R9", "done_o held", 32'(done), 1);
  endtask

  task automatic t_same_cycle;
    pdata[0] = 32'h6060_0003;
    cfg_m[3] = pdata[0];
    send(10'h043, 1, 1'b0, 1'b1);
    chk("R10", "done_o cleared", 32'(done), 0);
    chk_slots("R10 write with start");
    pdata[0] = 32'h5A5A_5A5A;
    send(10'h010, 1, 1'b0, 1'b0);
    chk("R10", "done_o re-set", 32'(done), 1);
    send(10'h010, 1, 1'b0, 1'b1);
    chk("R10", "done_o after start+fin", 32'(done), 1);
    pdata[0] = 32'h7070_0005;
    send(10'h045, 1, 1'b0, 1'b0);
    chk_slots("R10 dropped after fin");
  endtask

  initial begin
    for (int i = 0; i < 9; i++) cfg_m[i] = '0;
    for (int i = 0; i < 16; i++) pdata[i] = '0;
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    t_cfg_consec();
    t_nonconsec();
    t_alias();
    t_stall();
    t_action();
    t_unmapped();
    t_count0();
    t_finalize();
    t_drop();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule